// File: doc/BRIEF.md
# Random Allocation Tag Generator

This block picks a 4-bit memory allocation tag and writes it into bits 59:56 of a 64-bit pointer. In random mode the step count comes from a 16-bit shift-register seed that is advanced four times per request. The search starts at a tag held in a state word and moves forward through the tags that an exclusion mask allows. The updated state word, holding the new tag and the advanced seed, goes back to the caller for the next request.

In add-with-tag mode the start tag is read from the pointer itself, and a 4-bit immediate replaces the random step count. The address part becomes the pointer plus a sign-extended delta. The search walks one candidate tag per clock, so a request is taken with a one-cycle strobe and the result shows up with a one-cycle completion pulse.

Top module: `tag_gen_top`

## Requirements
- R1: In random mode (`mode_sel`=0) the tags to avoid are the bitwise OR of `ins_mask` and `ctl_mask`. Bit k set means tag k is excluded.
- R2: When the mask in force is 16'hFFFF, the result tag is 0, whatever the start tag or step count.
- R3: A random step takes feedback f = s[5]^s[3]^s[2]^s[0] and makes the new seed {f, s[15:1]}. Four steps run per request, and the f of step i (i = 0..3) becomes bit i of the step count.
- R4: With step count 0, the result is the start tag if that tag is allowed. Otherwise it is the first allowed tag found by counting up modulo 16.
- R5: With step count n > 0, the following is done n times: advance the tag by one modulo 16, then keep advancing while the current tag is excluded.
- R6: After a random request, `state_out` holds the new tag in bits 3:0, the four-times-advanced seed in bits 23:8, and zero in bits 7:4. The start tag is read from `state_in[3:0]` and the seed from `state_in[23:8]`.
- R7: When `state_in[23:8]` is zero and `rand_en` is 1, the seed 16'hACE1 (parameter `SUBST_SEED`) is used in its place. With `rand_en` at 0, a zero seed is used as it is.
- R8: In add-with-tag mode (`mode_sel`=1), the start tag is `ptr_in[59:56]` and the step count is `imm_off`. Only `ctl_mask` is used as the exclusion mask. The address part is `ptr_in` plus the sign-extended `addr_delta`, with bits 59:56 replaced by the tag. `state_out` does not change.
- R9: A request is taken only when `req_valid` is 1 and `busy` is 0. `done` is a one-cycle pulse during which `busy` is 0. A strobe sent while `busy` is 1 produces no result.
- R10: Each request completes within 16*15+3 clock cycles of being taken.
- R11: After reset, `busy`, `done`, `ptr_out` and `state_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| mode_sel | input | 1 | 0 random, 1 add-with-tag |
| ptr_in | input | 64 | Source pointer |
| ins_mask | input | 16 | Exclusion mask from the instruction operand |
| ctl_mask | input | 16 | Exclusion mask from the control register |
| rand_en | input | 1 | Allows a zero seed to be replaced |
| state_in | input | 24 | Start tag [3:0] and seed [23:8] |
| imm_off | input | 4 | Step count for add-with-tag mode |
| addr_delta | input | 16 | Signed address delta for add-with-tag mode |
| busy | output | 1 | Request in progress |
| done | output | 1 | Result valid pulse |
| ptr_out | output | 64 | Pointer with the new tag |
| state_out | output | 24 | Updated state word |

## Verification
The assertions check the following on every cycle:
- a completed search never lands on an excluded tag;
- a full mask yields tag 0;
- the search stays within its cycle bound;
- `done` never coincides with `busy`;
- the state tag field matches the pointer tag after a random request;
- add-with-tag requests leave the state word alone.

Only the bench scenarios can show that:
- the shift-register sequence and its bit order are right;
- the exact landing tag is right for each step count, including wrap-around;
- the replacement seed is used;
- the sign-extended address sum is right;
- a strobe sent while busy is dropped.

// File: rtl/tagsel_pkg.sv
package tagsel_pkg;
    localparam int TAG_W    = 4;
    localparam int NUM_TAGS = 1 << TAG_W;
    localparam int SEED_W   = 16;
    localparam int SEED_LSB = 8;
    localparam int STATE_W  = SEED_LSB + SEED_W;

    typedef logic [TAG_W-1:0]    tag_t;
    typedef logic [NUM_TAGS-1:0] excl_t;
    typedef logic [SEED_W-1:0]   seed_t;

    typedef enum logic {
        MODE_RANDOM = 1'b0,
        MODE_ADDTAG = 1'b1
    } gen_mode_e;

    typedef struct packed {
        seed_t next_seed;
        logic  fbit;
    } step_t;

    // One shift-register advance: feedback enters at the top.
    function automatic step_t lfsr_step(input seed_t s);
        step_t r;
        r.fbit      = s[5] ^ s[3] ^ s[2] ^ s[0];
        r.next_seed = {r.fbit, s[SEED_W-1:1]};
        return r;
    endfunction

    function automatic tag_t tag_inc(input tag_t t);
        return t + tag_t'(1);
    endfunction
endpackage

// File: rtl/tg_offset_gen.sv
module tg_offset_gen
    import tagsel_pkg::*;
#(
    parameter int STEPS = TAG_W
) (
    input  seed_t            seed_i,
    output logic [STEPS-1:0] offset_o,
    output seed_t            seed_o
);
    seed_t chain [0:STEPS];

    assign chain[0] = seed_i;

    for (genvar i = 0; i < STEPS; i++) begin : g_step
        step_t st;
        assign st           = lfsr_step(chain[i]);
        assign chain[i+1]   = st.next_seed;
        assign offset_o[i]  = st.fbit;   // step i -> bit i
    end

    assign seed_o = chain[STEPS];
endmodule

// File: rtl/tg_skip_walker.sv
module tg_skip_walker
    import tagsel_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  go,
    input  tag_t  start_tag,
    input  tag_t  step_cnt,
    input  excl_t excl,
    output logic  busy,
    output logic  done,
    output tag_t  tag_o
);
    localparam int LIMIT = NUM_TAGS * (NUM_TAGS - 1);
    localparam int CNT_W = $clog2(LIMIT + 2);
    localparam excl_t ALL_EX = '1;

    tag_t  cur_q, rem_q, res_q;
    excl_t mask_q;
    logic  busy_q, done_q;
    logic [CNT_W-1:0] cyc_q;
    tag_t  cand;

    assign cand = tag_inc(cur_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= '0;
            rem_q  <= '0;
            res_q  <= '0;
            mask_q <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
            cyc_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (go && !busy_q) begin
                mask_q <= excl;
                cyc_q  <= '0;
                if (excl == ALL_EX) begin
                    res_q  <= '0;
                    done_q <= 1'b1;
                end else begin
                    busy_q <= 1'b1;
                    // Count 0 is the same as one allowed hop from start-1.
                    if (step_cnt == '0) begin
                        cur_q <= start_tag - tag_t'(1);
                        rem_q <= tag_t'(1);
                    end else begin
                        cur_q <= start_tag;
                        rem_q <= step_cnt;
                    end
                end
            end else if (busy_q) begin
                cur_q <= cand;
                cyc_q <= cyc_q + 1'b1;
                if (!mask_q[cand]) begin
                    if (rem_q == tag_t'(1)) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                        res_q  <= cand;
                    end else begin
                        rem_q <= rem_q - tag_t'(1);
                    end
                end
            end
        end
    end

    assign busy  = busy_q;
    assign done  = done_q;
    assign tag_o = res_q;

    assert_tag_allowed_R5: assert property (@(posedge clk) disable iff (rst)
        (done_q && mask_q != ALL_EX) |-> !mask_q[res_q]);
    assert_full_mask_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (done_q && mask_q == ALL_EX) |-> (res_q == '0));
    assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !busy_q);
    assert_search_bound_R10: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (cyc_q < CNT_W'(LIMIT)));
endmodule

// File: rtl/tag_gen_top.sv
module tag_gen_top
    import tagsel_pkg::*;
#(
    parameter int    PTR_W      = 64,
    parameter int    TAG_LSB    = 56,
    parameter int    DELTA_W    = 16,
    parameter seed_t SUBST_SEED = 16'hACE1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               mode_sel,
    input  logic [PTR_W-1:0]   ptr_in,
    input  logic [NUM_TAGS-1:0] ins_mask,
    input  logic [NUM_TAGS-1:0] ctl_mask,
    input  logic               rand_en,
    input  logic [STATE_W-1:0] state_in,
    input  logic [TAG_W-1:0]   imm_off,
    input  logic [DELTA_W-1:0] addr_delta,
    output logic               busy,
    output logic               done,
    output logic [PTR_W-1:0]   ptr_out,
    output logic [STATE_W-1:0] state_out
);
    localparam int PAD_W = SEED_LSB - TAG_W;

    gen_mode_e mode_in, mode_q;
    seed_t     seed_raw, seed_eff, seed_adv, seed_q;
    tag_t      rnd_off, start_sel, cnt_sel, w_tag;
    excl_t     mask_sel;
    logic [PTR_W-1:0] base_sel, base_q, delta_ext;
    logic      w_busy, w_done, accept;
    logic      done_q;
    logic [PTR_W-1:0]   ptr_q;
    logic [STATE_W-1:0] state_q;
    logic [PAD_W-1:0]   unused_state_pad;

    assign unused_state_pad = state_in[SEED_LSB-1:TAG_W];

    assign mode_in   = gen_mode_e'(mode_sel);
    assign seed_raw  = state_in[SEED_LSB +: SEED_W];
    assign seed_eff  = (seed_raw == '0 && rand_en) ? SUBST_SEED : seed_raw;
    assign delta_ext = {{(PTR_W-DELTA_W){addr_delta[DELTA_W-1]}}, addr_delta};

    tg_offset_gen #(.STEPS(TAG_W)) u_offset (
        .seed_i  (seed_eff),
        .offset_o(rnd_off),
        .seed_o  (seed_adv)
    );

    always_comb begin
        if (mode_in == MODE_ADDTAG) begin
            start_sel = ptr_in[TAG_LSB +: TAG_W];
            cnt_sel   = imm_off;
            mask_sel  = ctl_mask;
            base_sel  = ptr_in + delta_ext;
        end else begin
            start_sel = state_in[TAG_W-1:0];
            cnt_sel   = rnd_off;
            mask_sel  = ins_mask | ctl_mask;
            base_sel  = ptr_in;
        end
    end

    assign busy   = w_busy | w_done;
    assign accept = req_valid && !busy;

    tg_skip_walker u_walk (
        .clk      (clk),
        .rst      (rst),
        .go       (accept),
        .start_tag(start_sel),
        .step_cnt (cnt_sel),
        .excl     (mask_sel),
        .busy     (w_busy),
        .done     (w_done),
        .tag_o    (w_tag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= MODE_RANDOM;
            seed_q  <= '0;
            base_q  <= '0;
            ptr_q   <= '0;
            state_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= w_done;
            if (accept) begin
                mode_q <= mode_in;
                seed_q <= seed_adv;
                base_q <= base_sel;
            end
            if (w_done) begin
                ptr_q <= base_q;
                ptr_q[TAG_LSB +: TAG_W] <= w_tag;
                if (mode_q == MODE_RANDOM)
                    state_q <= {seed_q, {PAD_W{1'b0}}, w_tag};
            end
        end
    end

    assign done      = done_q;
    assign ptr_out   = ptr_q;
    assign state_out = state_q;

    assert_state_tag_R6: assert property (@(posedge clk) disable iff (rst)
        (done_q && mode_q == MODE_RANDOM) |->
            (state_q[TAG_W-1:0] == ptr_q[TAG_LSB +: TAG_W]));
    assert_addtag_state_R8: assert property (@(posedge clk) disable iff (rst)
        (done_q && mode_q == MODE_ADDTAG) |-> $stable(state_q));
    assert_busy_drop_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && req_valid) |=> $stable(base_q));
endmodule

// File: tb/sim_tag_gen_top.sv
module sim_tag_gen_top;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_LAT    = 16 * 15 + 3;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, mode_sel, rand_en;
    logic [63:0] ptr_in;
    logic [15:0] ins_mask, ctl_mask, addr_delta;
    logic [23:0] state_in;
    logic [3:0]  imm_off;
    logic        busy, done;
    logic [63:0] ptr_out;
    logic [23:0] state_out;

    int n_checks = 0;
    int n_fail   = 0;
    logic [63:0] exp_ptr_q[$];
    logic [23:0] exp_state_q[$];
    string       exp_lbl_q[$];
    logic [23:0] last_state = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tag_gen_top u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .mode_sel(mode_sel),
        .ptr_in(ptr_in), .ins_mask(ins_mask), .ctl_mask(ctl_mask),
        .rand_en(rand_en), .state_in(state_in), .imm_off(imm_off),
        .addr_delta(addr_delta), .busy(busy), .done(done),
        .ptr_out(ptr_out), .state_out(state_out)
    );

    task automatic check(input string lbl, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", lbl, act, exp);
        end
    endtask

    // Reference tag search written from the requirements.
    function automatic logic [3:0] pick_tag(input logic [3:0] start, input logic [3:0] cnt,
                                            input logic [15:0] mask);
        logic [3:0] t = start;
        if (mask == 16'hFFFF) return 4'd0;
        if (cnt == 0) begin
            while (mask[t]) t = t + 4'd1;
        end else begin
            for (int k = 0; k < cnt; k++) begin
                t = t + 4'd1;
                while (mask[t]) t = t + 4'd1;
            end
        end
        return t;
    endfunction

    // Monitor: pops the scoreboard whenever a result appears.
    always @(negedge clk) begin
        if (!rst && done) begin
            if (exp_ptr_q.size() == 0) begin
                check("R9 unexpected done", 64'd1, 64'd0);
            end else begin
                string l;
                logic [63:0] ep;
                logic [23:0] es;
                ep = exp_ptr_q.pop_front();
                es = exp_state_q.pop_front();
                l  = exp_lbl_q.pop_front();
                check({l, " ptr_out"}, ptr_out, ep);
                check({l, " state_out"}, {40'd0, state_out}, {40'd0, es});
            end
        end
    end

    task automatic run_req(input logic m, input logic [63:0] p, input logic [15:0] im,
                           input logic [15:0] cm, input logic re, input logic [23:0] st,
                           input logic [3:0] io, input logic [15:0] dl, input string lbl,
                           input logic poke, output int lat);
        logic [63:0] ep;
        logic [23:0] es;
        logic [15:0] sd;
        logic [3:0]  off, tg;
        logic        fb;
        if (m) begin
            tg = pick_tag(p[59:56], io, cm);
            ep = p + {{48{dl[15]}}, dl};
            ep[59:56] = tg;
            es = last_state;
        end else begin
            sd = st[23:8];
            if (sd == 0 && re) sd = 16'hACE1;
            off = '0;
            for (int i = 0; i < 4; i++) begin
                fb = sd[5] ^ sd[3] ^ sd[2] ^ sd[0];
                sd = {fb, sd[15:1]};
                off[i] = fb;
            end
            tg = pick_tag(st[3:0], off, im | cm);
            ep = p;
            ep[59:56] = tg;
            es = {sd, 4'h0, tg};
            last_state = es;
        end
        exp_ptr_q.push_back(ep);
        exp_state_q.push_back(es);
        exp_lbl_q.push_back(lbl);
        @(negedge clk);
        req_valid = 1'b1; mode_sel = m; ptr_in = p; ins_mask = im; ctl_mask = cm;
        rand_en = re; state_in = st; imm_off = io; addr_delta = dl;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        if (poke) begin
            // Strobe while busy with different inputs: must be dropped.
            req_valid = 1'b1; mode_sel = 1'b0; ptr_in = '1; ins_mask = '0;
            ctl_mask = '0; state_in = 24'h123455;
            @(negedge clk);
            req_valid = 1'b0;
            lat++;
        end
        while (exp_ptr_q.size() != 0) begin
            @(negedge clk);
            lat++;
        end
        @(negedge clk);
        check({lbl, " R9 done pulse low"}, {63'd0, done}, 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int lat;
        logic [23:0] st;
        rst = 1'b1; req_valid = 1'b0; mode_sel = 1'b0; ptr_in = '0; ins_mask = '0;
        ctl_mask = '0; rand_en = 1'b0; state_in = '0; imm_off = '0; addr_delta = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R11 busy", {63'd0, busy}, 64'd0);
        check("R11 done", {63'd0, done}, 64'd0);
        check("R11 ptr_out", ptr_out, 64'd0);
        check("R11 state_out", {40'd0, state_out}, 64'd0);

        run_req(1'b0, 64'h0123_4567_89AB_CDEF, 16'h0, 16'h0, 1'b0, 24'h1234_03, 4'd0, 16'd0,
                "R3 R6 random basic", 1'b0, lat);
        run_req(1'b0, 64'h0F00_0000_0000_1000, 16'h00F0, 16'h0F00, 1'b0, 24'hBEEF_05, 4'd0, 16'd0,
                "R1 OR mask", 1'b0, lat);
        run_req(1'b0, 64'h0A00_0000_0000_2000, 16'hFF00, 16'h00FF, 1'b0, 24'h5A5A_07, 4'd0, 16'd0,
                "R2 full mask", 1'b0, lat);
        run_req(1'b1, 64'h0500_0000_0000_4000, 16'h0, 16'h0, 1'b0, 24'h0, 4'd0, 16'h0040,
                "R4 R8 start kept", 1'b0, lat);
        run_req(1'b1, 64'h0F00_0000_0000_4000, 16'hFFFF, 16'h8001, 1'b0, 24'h0, 4'd0, 16'h0010,
                "R4 R8 wrap ins ignored", 1'b0, lat);
        run_req(1'b1, 64'h0E00_0000_0000_4000, 16'h0, 16'h8002, 1'b0, 24'h0, 4'd3, 16'hFFC0,
                "R5 R8 skip negative delta", 1'b0, lat);
        run_req(1'b1, 64'h0000_0000_0000_8000, 16'h0, 16'h7FFE, 1'b0, 24'h0, 4'd15, 16'h0100,
                "R5 R9 long search busy strobe", 1'b1, lat);
        check("R10 latency bound", {63'd0, lat <= MAX_LAT}, 64'd1);
        run_req(1'b1, 64'h0300_0000_0000_0000, 16'h0, 16'hFFFF, 1'b0, 24'h0, 4'd9, 16'h0,
                "R2 add full mask", 1'b0, lat);
        run_req(1'b0, 64'h0100_0000_0000_0000, 16'h0, 16'h0, 1'b1, 24'h0000_09, 4'd0, 16'd0,
                "R7 zero seed replaced", 1'b0, lat);
        run_req(1'b0, 64'h0100_0000_0000_0000, 16'h0, 16'h0, 1'b0, 24'h0000_09, 4'd0, 16'd0,
                "R7 zero seed kept", 1'b0, lat);

        st = 24'hC3A5_0C;
        for (int j = 0; j < 6; j++) begin
            run_req(1'b0, 64'h00FF_0000_0000_0000 + 64'(j), 16'h0101 << j, 16'h1000 >> j, 1'b0,
                    st, 4'd0, 16'd0, "R6 chained state", 1'b0, lat);
            st = state_out;
        end

        check("R9 all results seen", 64'(exp_ptr_q.size()), 64'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule